// File: doc/BRIEF.md
# Gated Prescaled Timer Time Base

This block is a free-running period timer. It picks its count source from the system clock or one of several slow external clock inputs, divides that rate by a selectable prescaler, and advances a counter. The counter runs either as a 16-bit or a 32-bit time base. An optional gate, chosen from a group of gating sources, pauses counting while the chosen source is low.

When the counter reaches the period value, the next enabled tick wraps it to zero and raises a one-cycle match event. The match event leaves the block in four ways. It drives the converter-start trigger directly. It passes through a postscaler to form the interrupt and trigger pulses. It is also one of the choices for the synchronization output, which can instead pass on an alternate or an auxiliary sync input so that several timer units can be aligned.

Top module: `gated_timebase`

## Requirements
- R1: While `rst_n` is low and in the first sampled cycle after it, `count` is 0 and `match_evt`, `irq_pulse`, `evt_trig` and `adc_trig` are 0.
- R2: With `clk_sel`=0 (system clock) and `pre_sel`=0, `count` rises by one each cycle. After the edge where `count` equals the period, `count` reads 0 and `match_evt` is high for exactly that one cycle.
- R3: `pre_sel` codes 0, 1, 2 and 3 divide the tick rate by 1, 4, 16 and 64. The spacing between two matches is ratio × (period + 1) cycles.
- R4: With `mode32`=0, only `period[15:0]` is compared and the upper 16 bits of `count` stay 0.
- R5: With `mode32`=1, all 32 bits of `period` and `count` take part. A period above 65535 gives a first match after period + 1 cycles.
- R6: With `gate_en`=1, `count` holds while `gate_src[gate_sel]` is 0 and advances while it is 1. With `gate_en`=0, the gate sources have no effect.
- R7: `clk_sel`=k (k ≥ 1) counts rising edges of `ext_clk[k-1]`, one tick per edge. Edges on the other external inputs do not advance `count`.
- R8: `irq_pulse` and `evt_trig` pulse together, in the same cycle as a match, on every (`post_sel`+1)-th match.
- R9: `adc_trig` pulses with every match, without postscaling.
- R10: `sync_sel` picks `sync_out` as follows: 0 gives `match_evt`, 1 gives `alt_sync_in`, 2 gives `aux_sync_in`, and 3 gives 0.
- R11: While `enable` is 0, `count` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Counting enable |
| mode32 | input | 1 | 1 selects 32-bit time base, 0 selects 16-bit |
| clk_sel | input | 2 | Count source: 0 system clock, k external input k-1 |
| ext_clk | input | 3 | External count inputs, rising edge counted |
| pre_sel | input | 2 | Prescaler code (1,4,16,64) |
| gate_en | input | 1 | Gate qualification enable |
| gate_sel | input | 2 | Gating source index |
| gate_src | input | 4 | Gating sources, high lets counting proceed |
| period | input | 32 | Period value |
| post_sel | input | 4 | Postscaler code, ratio = code+1 |
| sync_sel | input | 2 | Sync output source select |
| alt_sync_in | input | 1 | Alternate sync source |
| aux_sync_in | input | 1 | Auxiliary sync source |
| count | output | 32 | Current counter value |
| match_evt | output | 1 | One-cycle period match event |
| irq_pulse | output | 1 | Postscaled interrupt pulse |
| evt_trig | output | 1 | Postscaled trigger pulse |
| adc_trig | output | 1 | Converter-start trigger, every match |
| sync_out | output | 1 | Synchronization output |

## Verification
The bench uses the default parameters: three external inputs, four gate sources and a 32-bit counter. With these values the whole select range is reachable. The bench visits every prescaler code, all sixteen postscaler codes, every sync choice and two of the external inputs. It also uses a 32-bit period just above 65535, which shows the difference between the two width modes within about 66,000 cycles.

// File: rtl/gtb_pkg.sv
package gtb_pkg;
    localparam int CNT_W  = 32;
    localparam int HALF_W = CNT_W / 2;
    localparam int PRE_W  = 6;
    localparam int POST_W = 4;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             match;
    } cnt_state_t;

    typedef struct packed {
        logic [PRE_W-1:0] phase;
    } pre_state_t;

    typedef struct packed {
        logic [POST_W-1:0] tally;
        logic              pulse;
    } post_state_t;
endpackage

// File: rtl/gtb_tick_src.sv
module gtb_tick_src #(
    parameter int NUM_EXT  = 3,
    parameter int NUM_GATE = 4,
    localparam int SEL_W   = $clog2(NUM_EXT + 1),
    localparam int GSEL_W  = (NUM_GATE > 1) ? $clog2(NUM_GATE) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SEL_W-1:0]    clk_sel,
    input  logic [NUM_EXT-1:0]  ext_clk,
    input  logic                gate_en,
    input  logic [GSEL_W-1:0]   gate_sel,
    input  logic [NUM_GATE-1:0] gate_src,
    output logic                raw_tick
);
    typedef struct packed {
        logic [NUM_EXT-1:0] smp;
        logic [NUM_EXT-1:0] prev;
    } edge_state_t;

    edge_state_t st_d, st_q;
    logic [NUM_EXT-1:0] rise;
    logic src_tick, gate_ok;

    always_comb begin
        st_d.smp  = ext_clk;
        st_d.prev = st_q.smp;
        rise      = st_q.smp & ~st_q.prev;
        src_tick  = (clk_sel == '0);
        for (int i = 0; i < NUM_EXT; i++) begin
            if (clk_sel == SEL_W'(i + 1)) src_tick = rise[i];
        end
        gate_ok = 1'b1;
        if (gate_en) begin
            gate_ok = 1'b0;
            for (int g = 0; g < NUM_GATE; g++) begin
                if (gate_sel == GSEL_W'(g)) gate_ok = gate_src[g];
            end
        end
        raw_tick = src_tick & gate_ok;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/gtb_prescaler.sv
module gtb_prescaler
    import gtb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       raw_tick,
    input  logic [1:0] pre_sel,
    output logic       adv
);
    pre_state_t st_d, st_q;
    logic [PRE_W-1:0] lim;

    always_comb begin
        lim  = (PRE_W'(1) << {pre_sel, 1'b0}) - PRE_W'(1);
        st_d = st_q;
        adv  = 1'b0;
        if (!enable) begin
            st_d.phase = '0;
        end else if (raw_tick) begin
            if (st_q.phase >= lim) begin
                st_d.phase = '0;
                adv        = 1'b1;
            end else begin
                st_d.phase = st_q.phase + PRE_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3: an advance restarts the divider phase
    assert_phase_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> (st_q.phase == '0));
endmodule

// File: rtl/gtb_postscaler.sv
module gtb_postscaler
    import gtb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              match_in,
    input  logic [POST_W-1:0] post_sel,
    output logic              pulse
);
    post_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (match_in) begin
            if (st_q.tally >= post_sel) begin
                st_d.tally = '0;
                st_d.pulse = 1'b1;
            end else begin
                st_d.tally = st_q.tally + POST_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pulse = st_q.pulse;

    // R8: every issued pulse leaves the tally restarted
    assert_tally_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pulse |-> (st_q.tally == '0));
endmodule

// File: rtl/gated_timebase.sv
module gated_timebase
    import gtb_pkg::*;
#(
    parameter int NUM_EXT  = 3,
    parameter int NUM_GATE = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enable,
    input  logic                 mode32,
    input  logic [1:0]           clk_sel,
    input  logic [NUM_EXT-1:0]   ext_clk,
    input  logic [1:0]           pre_sel,
    input  logic                 gate_en,
    input  logic [1:0]           gate_sel,
    input  logic [NUM_GATE-1:0]  gate_src,
    input  logic [CNT_W-1:0]     period,
    input  logic [POST_W-1:0]    post_sel,
    input  logic [1:0]           sync_sel,
    input  logic                 alt_sync_in,
    input  logic                 aux_sync_in,
    output logic [CNT_W-1:0]     count,
    output logic                 match_evt,
    output logic                 irq_pulse,
    output logic                 evt_trig,
    output logic                 adc_trig,
    output logic                 sync_out
);
    logic raw_tick, adv, hit, post_pulse;
    logic [CNT_W-1:0] cnt_eff, per_eff, cnt_inc;
    cnt_state_t st_d, st_q;

    gtb_tick_src #(.NUM_EXT(NUM_EXT), .NUM_GATE(NUM_GATE)) u_src (
        .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .ext_clk(ext_clk),
        .gate_en(gate_en), .gate_sel(gate_sel), .gate_src(gate_src),
        .raw_tick(raw_tick)
    );

    gtb_prescaler u_pre (
        .clk(clk), .rst_n(rst_n), .enable(enable), .raw_tick(raw_tick),
        .pre_sel(pre_sel), .adv(adv)
    );

    always_comb begin
        cnt_eff = mode32 ? st_q.cnt : {{HALF_W{1'b0}}, st_q.cnt[HALF_W-1:0]};
        per_eff = mode32 ? period   : {{HALF_W{1'b0}}, period[HALF_W-1:0]};
        cnt_inc = cnt_eff + CNT_W'(1);
        if (!mode32) cnt_inc[CNT_W-1:HALF_W] = '0;
        hit        = adv && (cnt_eff == per_eff);
        st_d.cnt   = cnt_eff;
        st_d.match = 1'b0;
        if (adv) begin
            if (hit) begin
                st_d.cnt   = '0;
                st_d.match = 1'b1;
            end else begin
                st_d.cnt = cnt_inc;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    gtb_postscaler u_post (
        .clk(clk), .rst_n(rst_n), .match_in(hit), .post_sel(post_sel),
        .pulse(post_pulse)
    );

    always_comb begin
        unique case (sync_sel)
            2'd0:    sync_out = st_q.match;
            2'd1:    sync_out = alt_sync_in;
            2'd2:    sync_out = aux_sync_in;
            default: sync_out = 1'b0;
        endcase
    end

    assign count     = st_q.cnt;
    assign match_evt = st_q.match;
    assign irq_pulse = post_pulse;
    assign evt_trig  = post_pulse;
    assign adc_trig  = st_q.match;

    // R2: a match always shows a wrapped counter
    assert_wrap_on_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
        match_evt |-> (count == '0));
    // R4: 16-bit mode keeps the upper half clear
    assert_upper_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!mode32) |-> (count[CNT_W-1:HALF_W] == '0));
    // R6 / R11: no advance means the counter holds
    assert_hold_no_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && (mode32 || count[CNT_W-1:HALF_W] == '0)) |=> $stable(count));
    // R8: postscaled pulse only coincides with a match
    assert_pulse_on_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> match_evt);
endmodule

// File: tb/gated_timebase_test.sv
module gated_timebase_test;
    logic clk = 1'b0;
    logic rst_n, enable, mode32, gate_en, alt_sync_in, aux_sync_in;
    logic [1:0] clk_sel, pre_sel, gate_sel, sync_sel;
    logic [2:0] ext_clk;
    logic [3:0] gate_src, post_sel;
    logic [31:0] period, count;
    logic match_evt, irq_pulse, evt_trig, adc_trig, sync_out;
    int checks = 0, fails = 0;

    always #5 clk = ~clk;

    gated_timebase uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .mode32(mode32),
        .clk_sel(clk_sel), .ext_clk(ext_clk), .pre_sel(pre_sel),
        .gate_en(gate_en), .gate_sel(gate_sel), .gate_src(gate_src),
        .period(period), .post_sel(post_sel), .sync_sel(sync_sel),
        .alt_sync_in(alt_sync_in), .aux_sync_in(aux_sync_in),
        .count(count), .match_evt(match_evt), .irq_pulse(irq_pulse),
        .evt_trig(evt_trig), .adc_trig(adc_trig), .sync_out(sync_out)
    );

    task automatic check(string req, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic restart();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic until_match(output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (!match_evt && n < 100000);
    endtask

    task automatic pulse_ext(int idx, int times);
        for (int k = 0; k < times; k++) begin
            ext_clk[idx] = 1'b1; repeat (2) @(negedge clk);
            ext_clk[idx] = 1'b0; repeat (2) @(negedge clk);
        end
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int n, c0, irqs, mats, adcs, bad;
        rst_n = 1'b0; enable = 1'b1; mode32 = 1'b0; clk_sel = 2'd0; ext_clk = '0;
        pre_sel = 2'd0; gate_en = 1'b0; gate_sel = 2'd0; gate_src = '0;
        period = 32'd4; post_sel = 4'd0; sync_sel = 2'd0;
        alt_sync_in = 1'b0; aux_sync_in = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 count", count, 0);
        check("R1 outputs", {match_evt, irq_pulse, evt_trig, adc_trig}, 0);
        rst_n = 1'b1;
        // R2 sequence with period 4, R10 code 0 follows match
        bad = 0;
        for (int i = 1; i <= 12; i++) begin
            @(negedge clk);
            check("R2 count", count, i % 5);
            check("R2 match", match_evt, (i % 5 == 0) ? 1 : 0);
            if (sync_out != match_evt) bad++;
        end
        check("R10 sync code0", bad, 0);
        // R3 prescaler sweep
        for (int p = 0; p < 4; p++) begin
            pre_sel = 2'(p); period = 32'd3;
            restart();
            until_match(n); until_match(n);
            check("R3 interval", n, (1 << (2 * p)) * 4);
        end
        pre_sel = 2'd0;
        // R4 16-bit uses low half only
        period = 32'h0001_0005; mode32 = 1'b0;
        restart(); until_match(n);
        check("R4 first match", n, 6);
        check("R4 upper clear", count[31:16], 0);
        // R5 32-bit full width
        mode32 = 1'b1;
        restart(); until_match(n);
        check("R5 first match", n, 32'h0001_0006);
        mode32 = 1'b0;
        // R6 gate
        period = 32'd1000; gate_en = 1'b1; gate_sel = 2'd2; gate_src = 4'b1011;
        restart(); repeat (5) @(negedge clk); c0 = count;
        repeat (20) @(negedge clk);
        check("R6 gated hold", count, c0);
        gate_src[2] = 1'b1; @(negedge clk); c0 = count;
        repeat (10) @(negedge clk);
        check("R6 gate open", count, c0 + 10);
        gate_en = 1'b0; gate_src = '0; c0 = count;
        repeat (10) @(negedge clk);
        check("R6 gate disabled", count, c0 + 10);
        // R11 enable low holds
        enable = 1'b0; @(negedge clk); c0 = count;
        repeat (10) @(negedge clk);
        check("R11 hold", count, c0);
        enable = 1'b1;
        // R7 external clock select
        clk_sel = 2'd2; restart();
        pulse_ext(0, 5); pulse_ext(2, 3);
        check("R7 other inputs ignored", count, 0);
        pulse_ext(1, 7); repeat (3) @(negedge clk);
        check("R7 edges counted", count, 7);
        clk_sel = 2'd0;
        // R8 / R9 postscaler sweep
        period = 32'd1;
        for (int s = 0; s < 16; s++) begin
            post_sel = 4'(s); restart();
            irqs = 0; mats = 0; adcs = 0; bad = 0;
            for (int i = 0; i < 6 * (s + 1); i++) begin
                @(negedge clk);
                irqs += irq_pulse; mats += match_evt; adcs += adc_trig;
                if (evt_trig != irq_pulse || (irq_pulse && !match_evt)) bad++;
            end
            check("R8 irq count", irqs, 3);
            check("R8 trig agrees", bad, 0);
            check("R9 adc every match", adcs, 3 * (s + 1));
        end
        // R10 sync select
        sync_sel = 2'd1; alt_sync_in = 1'b1; #1;
        check("R10 alt high", sync_out, 1);
        alt_sync_in = 1'b0; #1;
        check("R10 alt low", sync_out, 0);
        sync_sel = 2'd2; aux_sync_in = 1'b1; #1;
        check("R10 aux", sync_out, 1);
        sync_sel = 2'd3; alt_sync_in = 1'b1; #1;
        check("R10 code3", sync_out, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule